// File: doc/BRIEF.md
# Multichannel DMA Control Register Block

This block holds the control and status words of a memory-access layer that serves a number of transmit and receive DMA channels. A processor reaches it through a register port. The port carries a 10-bit register number, separate read and write strobes, and 32-bit write and read data. Reads are combinational: the value appears on `rdata` in the same cycle that `rd_en` is high. Writes take effect on the rising clock edge on which `wr_en` is high.

The shared words are:

- a configuration word;
- an error status word;
- an interrupt enable word;
- activate and deactivate request words, one pair for transmit and one pair for receive;
- an end-of-buffer status word and a descriptor-error status word for each direction.

Each channel also has its own registers, laid out in three windows. Each window holds one register per configured channel:

- transmit descriptor-table pointers;
- receive descriptor-table pointers;
- receive buffer sizes.

The parameters `TX_CHANNELS` and `RX_CHANNELS` set the two channel counts. Each must lie in 1..32, and elaboration stops with an error outside that range.

Setting bit 31 in a configuration write starts a software clear. The clear empties the enable, activate and status words and leaves every channel window untouched. Descriptor fetch, data movement and the driving of interrupt lines belong to other blocks.

Top module: `dma_csr_block`

## Requirements
- R1: After `rst_n` is deasserted, the configuration word reads 0x0007C000. Every other mapped register, including all channel window slots, reads zero.
- R2: The shared words sit at fixed register numbers. Configuration is 0x180, error status 0x181 and interrupt enable 0x182. Transmit activate and deactivate are 0x184 and 0x185. Transmit end-of-buffer status is 0x186 and transmit descriptor-error status is 0x187. Registers 0x190 to 0x193 are the receive counterparts, in that same order.
- R3: A configuration write with bit 31 set does two things. It clears error status, interrupt enable, both activate words and all four interrupt status words. It then stores the written value ANDed with 0x00FFC087 into the configuration word.
- R4: Writes keep only these bits:
  - configuration: the bits of 0x00FFC087;
  - interrupt enable: bits 4:0;
  - transmit activate and deactivate: bits 31:28;
  - receive activate and deactivate: bits 31:30;
  - receive buffer size: bits 7:0.
- R5: Writing the error status word or any of the four interrupt status words clears the bits written as one and leaves the other bits unchanged. No other register changes.
- R6: Transmit pointer slot k is at register 0x1A0+k. Receive pointer slot k is at 0x1C0+k, and receive buffer size slot k is at 0x1E0+k. Each slot exists for k below its direction's channel count, and pointer slots keep all 32 bits.
- R7: A read of an unmapped register number, or of a window slot at or beyond the channel count, returns zero. A write to such a number changes no register.
- R8: The software clear leaves the channel windows and both deactivate words unchanged.
- R9: `rdata` is zero whenever `rd_en` is low.
- R10: When `rd_en` and `wr_en` are high in the same cycle on the same register, the read returns the value held before the write. The new value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_num | input | 10 | Register number |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |

## Verification
The bench probes the window edges. It writes one slot past each channel count and reads the slot back. A decoder that was off by one would answer with the written value or overwrite a neighbouring channel.

It issues a software clear after loading every register. A design that cleared too much would lose the pointers, sizes or deactivate words. One that cleared too little would keep the enable or activate bits, and one that ordered the clear after the store would leave a stale configuration.

It writes all ones to every masked word. A missing mask shows up as stray high bits.

It also reads and writes in the same cycle. A design that bypassed write data into the read path would return the new value one cycle early.

// File: rtl/dma_csr_block.sv
module dma_csr_block #(
  parameter int TX_CHANNELS = 4,
  parameter int RX_CHANNELS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  reg_num,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam logic [9:0]  A_CFG      = 10'h180;
  localparam logic [9:0]  A_ERR      = 10'h181;
  localparam logic [9:0]  A_IEN      = 10'h182;
  localparam logic [9:0]  A_TX_SET   = 10'h184;
  localparam logic [9:0]  A_TX_CLR   = 10'h185;
  localparam logic [9:0]  A_TX_EOB   = 10'h186;
  localparam logic [9:0]  A_TX_DERR  = 10'h187;
  localparam logic [9:0]  A_RX_SET   = 10'h190;
  localparam logic [9:0]  A_RX_CLR   = 10'h191;
  localparam logic [9:0]  A_RX_EOB   = 10'h192;
  localparam logic [9:0]  A_RX_DERR  = 10'h193;
  localparam logic [9:0]  TXP_BASE   = 10'h1A0;
  localparam logic [9:0]  RXP_BASE   = 10'h1C0;
  localparam logic [9:0]  RXB_BASE   = 10'h1E0;
  localparam logic [31:0] CFG_INIT   = 32'h0007_C000;
  localparam logic [31:0] CFG_MASK   = 32'h00FF_C087;
  localparam logic [31:0] IEN_MASK   = 32'h0000_001F;
  localparam logic [31:0] TXACT_MASK = 32'hF000_0000;
  localparam logic [31:0] RXACT_MASK = 32'hC000_0000;
  localparam logic [31:0] BSZ_MASK   = 32'h0000_00FF;

  if (TX_CHANNELS < 1 || TX_CHANNELS > 32) begin : g_bad_tx
    $error("TX_CHANNELS must lie in 1..32");
  end
  if (RX_CHANNELS < 1 || RX_CHANNELS > 32) begin : g_bad_rx
    $error("RX_CHANNELS must lie in 1..32");
  end

  logic [31:0] cfg, err_stat, irq_en;
  logic [31:0] tx_act_set, tx_act_rst, tx_eob, tx_derr;
  logic [31:0] rx_act_set, rx_act_rst, rx_eob, rx_derr;
  logic [31:0] tx_ptr [TX_CHANNELS];
  logic [31:0] rx_ptr [RX_CHANNELS];
  logic [31:0] rx_bsz [RX_CHANNELS];
  logic [31:0] rd_mux;

  wire soft_clr = wr_en && reg_num == A_CFG && wdata[31];

  // Shared words; the software clear (R3) precedes the masked store (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= CFG_INIT;
      err_stat   <= '0;
      irq_en     <= '0;
      tx_act_set <= '0;
      tx_act_rst <= '0;
      tx_eob     <= '0;
      tx_derr    <= '0;
      rx_act_set <= '0;
      rx_act_rst <= '0;
      rx_eob     <= '0;
      rx_derr    <= '0;
    end else if (wr_en) begin
      if (soft_clr) begin
        err_stat   <= '0;
        irq_en     <= '0;
        tx_act_set <= '0;
        tx_eob     <= '0;
        tx_derr    <= '0;
        rx_act_set <= '0;
        rx_eob     <= '0;
        rx_derr    <= '0;
      end
      case (reg_num)
        A_CFG:     cfg        <= wdata & CFG_MASK;
        A_ERR:     err_stat   <= err_stat & ~wdata;
        A_IEN:     irq_en     <= wdata & IEN_MASK;
        A_TX_SET:  tx_act_set <= wdata & TXACT_MASK;
        A_TX_CLR:  tx_act_rst <= wdata & TXACT_MASK;
        A_TX_EOB:  tx_eob     <= tx_eob & ~wdata;
        A_TX_DERR: tx_derr    <= tx_derr & ~wdata;
        A_RX_SET:  rx_act_set <= wdata & RXACT_MASK;
        A_RX_CLR:  rx_act_rst <= wdata & RXACT_MASK;
        A_RX_EOB:  rx_eob     <= rx_eob & ~wdata;
        A_RX_DERR: rx_derr    <= rx_derr & ~wdata;
        default: ;
      endcase
    end
  end

  // Channel windows: hardware reset only, untouched by the software clear (R8)
  for (genvar t = 0; t < TX_CHANNELS; t++) begin : g_tx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tx_ptr[t] <= '0;
      else if (wr_en && reg_num == TXP_BASE + 10'(t))
        tx_ptr[t] <= wdata;
    end
  end

  for (genvar r = 0; r < RX_CHANNELS; r++) begin : g_rx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_ptr[r] <= '0;
        rx_bsz[r] <= '0;
      end else if (wr_en) begin
        if (reg_num == RXP_BASE + 10'(r)) rx_ptr[r] <= wdata;
        if (reg_num == RXB_BASE + 10'(r)) rx_bsz[r] <= wdata & BSZ_MASK;
      end
    end
  end

  // Read path; unmapped numbers and slots past the channel count read zero (R7)
  always_comb begin
    case (reg_num)
      A_CFG:     rd_mux = cfg;
      A_ERR:     rd_mux = err_stat;
      A_IEN:     rd_mux = irq_en;
      A_TX_SET:  rd_mux = tx_act_set;
      A_TX_CLR:  rd_mux = tx_act_rst;
      A_TX_EOB:  rd_mux = tx_eob;
      A_TX_DERR: rd_mux = tx_derr;
      A_RX_SET:  rd_mux = rx_act_set;
      A_RX_CLR:  rd_mux = rx_act_rst;
      A_RX_EOB:  rd_mux = rx_eob;
      A_RX_DERR: rd_mux = rx_derr;
      default:   rd_mux = '0;
    endcase
    for (int i = 0; i < TX_CHANNELS; i++)
      if (reg_num == TXP_BASE + 10'(i)) rd_mux = tx_ptr[i];
    for (int i = 0; i < RX_CHANNELS; i++) begin
      if (reg_num == RXP_BASE + 10'(i)) rd_mux = rx_ptr[i];
      if (reg_num == RXB_BASE + 10'(i)) rd_mux = rx_bsz[i];
    end
  end

  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/dma_csr_checker.sv
module dma_csr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  reg_num,
  input logic        rd_en,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [31:0] err_stat,
  input logic [31:0] irq_en,
  input logic [31:0] tx_act_set,
  input logic [31:0] tx_act_rst,
  input logic [31:0] rx_act_set,
  input logic [31:0] rx_act_rst
);
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_num == 10'h180 && wdata[31]) |=> (irq_en == 0 && tx_act_set == 0 && rx_act_set == 0)); // R3

  AST_IEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_num == 10'h182) |=> irq_en == {27'd0, $past(wdata[4:0])}); // R4

  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_num == 10'h181) |=> (err_stat & $past(wdata)) == 0); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_num == 10'h183) |-> rdata == 0); // R7

  AST_DEACT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_num == 10'h180 && wdata[31]) |=> ($stable(tx_act_rst) && $stable(rx_act_rst))); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 0); // R9
endmodule

bind dma_csr_block dma_csr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .err_stat(err_stat), .irq_en(irq_en),
  .tx_act_set(tx_act_set), .tx_act_rst(tx_act_rst),
  .rx_act_set(rx_act_set), .rx_act_rst(rx_act_rst)
);

// File: tb/dma_csr_block_tb.sv
module dma_csr_block_tb;
  localparam int TXN = 4;
  localparam int RXN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_num = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dma_csr_block #(.TX_CHANNELS(TXN), .RX_CHANNELS(RXN)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
  );

  // Monitor: compares every read against the scoreboard head
  always @(negedge clk) begin
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL monitor: unexpected read of 0x%0h, actual %08h expected none", reg_num, rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s reg 0x%0h: actual %08h expected %08h", t, reg_num, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_num = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    reg_num = a; rd_en = 1'b1; wr_en = 1'b0;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rdwr(input logic [9:0] a, input logic [31:0] d, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    reg_num = a; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(10'h180, 32'h0007C000, "R1 cfg reset");
    rd(10'h182, 32'h0, "R1 ien reset");
    rd(10'h1A0, 32'h0, "R1 txptr reset");
    rd(10'h1E1, 32'h0, "R1 bufsz reset");

    // R9 idle read data
    @(posedge clk); #1 reg_num = 10'h180; rd_en = 1'b0;
    @(negedge clk);
    checks++;
    if (rdata !== 32'h0) begin
      failures++;
      $display("FAIL R9 idle rdata: actual %08h expected 00000000", rdata);
    end

    // R2 / R4 masked stores
    wr(10'h180, 32'h00000081);
    rd(10'h180, 32'h00000081, "R2 cfg store");
    wr(10'h180, 32'h7FFFFFFF);
    rd(10'h180, 32'h00FFC087, "R4 cfg mask");
    wr(10'h182, 32'hFFFFFFFF);
    rd(10'h182, 32'h0000001F, "R4 ien mask");
    wr(10'h184, 32'hFFFFFFFF);
    rd(10'h184, 32'hF0000000, "R4 txset mask");
    wr(10'h185, 32'hFFFFFFFF);
    rd(10'h185, 32'hF0000000, "R4 txclr mask");
    wr(10'h190, 32'hFFFFFFFF);
    rd(10'h190, 32'hC0000000, "R4 rxset mask");
    wr(10'h191, 32'hFFFFFFFF);
    rd(10'h191, 32'hC0000000, "R4 rxclr mask");
    wr(10'h1E1, 32'h00012345);
    rd(10'h1E1, 32'h00000045, "R4 bufsz mask");

    // R6 channel windows
    for (int k = 0; k < TXN; k++) wr(10'h1A0 + 10'(k), 32'hA5A50000 + 32'(k));
    for (int k = 0; k < RXN; k++) wr(10'h1C0 + 10'(k), 32'h5A5A0000 + 32'(k));
    wr(10'h1E0, 32'h000000EE);
    for (int k = 0; k < TXN; k++) rd(10'h1A0 + 10'(k), 32'hA5A50000 + 32'(k), "R6 txptr");
    for (int k = 0; k < RXN; k++) rd(10'h1C0 + 10'(k), 32'h5A5A0000 + 32'(k), "R6 rxptr");

    // R7 unmapped and past-the-end slots
    wr(10'h1A0 + 10'(TXN), 32'hDEADBEEF);
    rd(10'h1A0 + 10'(TXN), 32'h0, "R7 txptr past end");
    rd(10'h1A0 + 10'(TXN - 1), 32'hA5A50000 + 32'(TXN - 1), "R7 last txptr kept");
    wr(10'h1C0 + 10'(RXN), 32'hDEADBEEF);
    rd(10'h1C0 + 10'(RXN), 32'h0, "R7 rxptr past end");
    wr(10'h1E0 + 10'(RXN), 32'h000000AA);
    rd(10'h1E0 + 10'(RXN), 32'h0, "R7 bufsz past end");
    rd(10'h1E1, 32'h00000045, "R7 last bufsz kept");
    wr(10'h183, 32'hFFFFFFFF);
    rd(10'h183, 32'h0, "R7 unmapped");
    rd(10'h182, 32'h0000001F, "R7 ien after stray write");

    // R5 write-one-to-clear
    wr(10'h181, 32'hFFFFFFFF);
    rd(10'h181, 32'h0, "R5 err w1c");
    wr(10'h186, 32'h0F0F0F0F);
    rd(10'h186, 32'h0, "R5 txeob w1c");
    rd(10'h182, 32'h0000001F, "R5 ien untouched");
    rd(10'h184, 32'hF0000000, "R5 txset untouched");

    // R10 read during write
    rdwr(10'h182, 32'h00000003, 32'h0000001F, "R10 old value");
    rd(10'h182, 32'h00000003, "R10 new value");

    // R3 / R8 software clear
    wr(10'h180, 32'h80000001);
    rd(10'h180, 32'h00000001, "R3 cfg after clear");
    rd(10'h182, 32'h0, "R3 ien cleared");
    rd(10'h184, 32'h0, "R3 txset cleared");
    rd(10'h190, 32'h0, "R3 rxset cleared");
    rd(10'h185, 32'hF0000000, "R8 txclr kept");
    rd(10'h191, 32'hC0000000, "R8 rxclr kept");
    rd(10'h1A1, 32'hA5A50001, "R8 txptr kept");
    rd(10'h1C1, 32'h5A5A0001, "R8 rxptr kept");
    rd(10'h1E0, 32'h000000EE, "R8 bufsz kept");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule